// File: doc/BRIEF.md
# Timer Compare Output Unit

The unit watches one of two 16-bit timer counts, chosen by a select input, and tests it for equality against a programmable compare value on every clock cycle. When the count becomes equal to the compare value, the unit performs the action chosen by a 4-bit mode field. It can drive its output latch high or low, or toggle it. It can raise an interrupt flag and leave the latch unchanged. It can also pulse a reset back to the timer in use, which makes the compare value act as that timer's period.

Software programs the unit through a small write port. Address 0 is the control word and address 1 is the compare value. The interrupt flag stays set until a clear input is pulsed. A separate interrupt output presents the flag gated by an enable bit held in the control word.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset, pin_o, irq_flag_o, irq_o, tmr_a_rst_o and tmr_b_rst_o are all 0, and compare is disabled.
- R2: Mode 4'b1000 (control bits 3:0) drives pin_o to 1 on the clock edge that ends the first cycle in which the selected timer equals the compare value.
- R3: Mode 4'b1001 drives pin_o to 0 on that same edge.
- R4: Mode 4'b0010 inverts pin_o on that same edge.
- R5: Mode 4'b1010 sets the interrupt flag on a match and leaves pin_o unchanged.
- R6: In mode 4'b1011, a match drives the reset output of the selected timer (tmr_a_rst_o when tmr_sel_i=0, tmr_b_rst_o when tmr_sel_i=1) high for that single cycle. The reset output of the other timer stays 0, and pin_o does not change.
- R7: Every match in an active mode sets irq_flag_o on the following edge. The flag holds until flag_clr_i is pulsed. When a clear and a match fall in the same cycle, the flag stays set.
- R8: An action fires once per entry into equality. While the timer stays at the compare value, no further action occurs.
- R9: Only the timer chosen by tmr_sel_i is compared. The other timer bus has no effect.
- R10: A write of 16'h0000 to address 0 forces pin_o to 0 on the next edge. A write of a non-zero control word does not change pin_o. A new mode takes effect from the cycle after its write.
- R11: Any mode code outside 1000, 1001, 0010, 1010 and 1011 disables compare: matches leave pin_o, the flag and the reset outputs alone.
- R12: irq_o equals irq_flag_o ANDed with control bit 4. The flag is set regardless of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: control word, 1: compare value |
| wr_data_i | input | 16 | Write data; control uses bit 4 = irq enable, bits 3:0 = mode |
| tmr_sel_i | input | 1 | Time base select: 0 timer A, 1 timer B |
| tmr_a_i | input | 16 | Timer A count |
| tmr_b_i | input | 16 | Timer B count |
| tmr_a_rst_o | output | 1 | Reset pulse to timer A |
| tmr_b_rst_o | output | 1 | Reset pulse to timer B |
| pin_o | output | 1 | Compare output latch |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Flag gated by the enable bit |

## Verification
The bench holds a timer at the compare value for several cycles. A unit that matched on level rather than on entry would set the flag again, so a flag cleared during the hold would come back. It pulses a clear in the same cycle as a match, where a unit that gave the clear priority would lose the event. It switches the time base to timer B while timer A sits at the compare value, so a unit that ignored the select would pulse the wrong reset. It also writes an undefined mode and then a zero control word while the latch is high. A unit that decoded modes loosely would move the latch on the match, and one that skipped the forced clear would leave the latch high.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET    = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR    = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_SWI    = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_SEV    = 4'b1011;

  typedef struct packed {
    logic              irq_en;
    logic [MODE_W-1:0] mode;
  } cmp_ctrl_t;

  localparam int CTRL_W = $bits(cmp_ctrl_t);

  function automatic logic mode_active(logic [MODE_W-1:0] m);
    return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR) ||
           (m == MODE_SWI) || (m == MODE_SEV);
  endfunction
endpackage

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_sel_i,
  input  logic [TMR_W-1:0] tmr_a_i,
  input  logic [TMR_W-1:0] tmr_b_i,
  input  logic [TMR_W-1:0] cmp_val_i,
  input  logic             active_i,
  output logic             hit_o
);
  logic [TMR_W-1:0] cnt;
  logic             eq, eq_q;

  assign cnt = tmr_sel_i ? tmr_b_i : tmr_a_i;
  assign eq  = (cnt == cmp_val_i);

  // edge qualification: act only on entry into equality
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  assign hit_o = eq & ~eq_q & active_i;
endmodule

// File: rtl/cmp_pin_ctl.sv
module cmp_pin_ctl
  import cmp_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              force_low_i,
  output logic              pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (force_low_i) begin
      pin_q <= 1'b0;
    end else if (hit_i) begin
      unique case (mode_i)
        MODE_SET:    pin_q <= 1'b1;
        MODE_CLR:    pin_q <= 1'b0;
        MODE_TOGGLE: pin_q <= ~pin_q;
        default:     pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/cmp_irq_flag.sv
module cmp_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  input  logic             tmr_sel_i,
  input  logic [TMR_W-1:0] tmr_a_i,
  input  logic [TMR_W-1:0] tmr_b_i,
  output logic             tmr_a_rst_o,
  output logic             tmr_b_rst_o,
  output logic             pin_o,
  input  logic             flag_clr_i,
  output logic             irq_flag_o,
  output logic             irq_o
);
  cmp_ctrl_t        ctrl_q;
  logic [TMR_W-1:0] cmp_q;
  logic             ctrl_wr, cmp_wr, ctrl_zero_wr;
  logic             hit, sev_fire;

  assign ctrl_wr      = wr_en_i & ~wr_addr_i;
  assign cmp_wr       = wr_en_i &  wr_addr_i;
  assign ctrl_zero_wr = ctrl_wr & (wr_data_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= cmp_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (cmp_wr)  cmp_q  <= wr_data_i;
    end
  end

  cmp_match_det #(.TMR_W(TMR_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmr_sel_i (tmr_sel_i),
    .tmr_a_i   (tmr_a_i),
    .tmr_b_i   (tmr_b_i),
    .cmp_val_i (cmp_q),
    .active_i  (mode_active(ctrl_q.mode)),
    .hit_o     (hit)
  );

  cmp_pin_ctl u_pin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .mode_i      (ctrl_q.mode),
    .force_low_i (ctrl_zero_wr),
    .pin_o       (pin_o)
  );

  cmp_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (flag_clr_i),
    .en_i   (ctrl_q.irq_en),
    .flag_o (irq_flag_o),
    .irq_o  (irq_o)
  );

  // special event: single-cycle reset to the timer in use
  assign sev_fire    = hit & (ctrl_q.mode == MODE_SEV);
  assign tmr_a_rst_o = sev_fire & ~tmr_sel_i;
  assign tmr_b_rst_o = sev_fire &  tmr_sel_i;
endmodule

// File: rtl/cmp_out_chk.sv
module cmp_out_chk
  import cmp_out_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_addr_i,
  input logic [TMR_W-1:0]  wr_data_i,
  input logic              tmr_a_rst_o,
  input logic              tmr_b_rst_o,
  input logic              pin_o,
  input logic              flag_clr_i,
  input logic              irq_flag_o,
  input logic              irq_o,
  input logic [MODE_W-1:0] mode_q
);
  a_r6_rst_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tmr_a_rst_o, tmr_b_rst_o}));

  a_r8_rst_a_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_a_rst_o |=> !tmr_a_rst_o);

  a_r8_rst_b_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_b_rst_o |=> !tmr_b_rst_o);

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o);

  a_r10_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i && wr_data_i == '0) |=> !pin_o);

  a_r5_swi_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SWI && !wr_en_i) |=> $stable(pin_o));

  a_r12_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_flag_o);
endmodule

bind cmp_out_unit cmp_out_chk #(.TMR_W(TMR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .tmr_a_rst_o (tmr_a_rst_o),
  .tmr_b_rst_o (tmr_b_rst_o),
  .pin_o       (pin_o),
  .flag_clr_i  (flag_clr_i),
  .irq_flag_o  (irq_flag_o),
  .irq_o       (irq_o),
  .mode_q      (ctrl_q.mode)
);

// File: tb/cmp_out_unit_tb_top.sv
module cmp_out_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        tmr_sel_i = 1'b0;
  logic [15:0] tmr_a_i = '0;
  logic [15:0] tmr_b_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        tmr_a_rst_o, tmr_b_rst_o, pin_o, irq_flag_o, irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [4:0] exp;  // {pin, flag, irq, rst_a, rst_b}
    string      req;
  } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  cmp_out_unit dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .tmr_sel_i   (tmr_sel_i),
    .tmr_a_i     (tmr_a_i),
    .tmr_b_i     (tmr_b_i),
    .tmr_a_rst_o (tmr_a_rst_o),
    .tmr_b_rst_o (tmr_b_rst_o),
    .pin_o       (pin_o),
    .flag_clr_i  (flag_clr_i),
    .irq_flag_o  (irq_flag_o),
    .irq_o       (irq_o)
  );

  // monitor: compare outputs at mid-cycle against queued expectations
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = sb_q.pop_front();
      act = {pin_o, irq_flag_o, irq_o, tmr_a_rst_o, tmr_b_rst_o};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s {pin,flag,irq,rst_a,rst_b} actual=%b expected=%b",
                 it.req, act, it.exp);
      end
    end
  end

  task automatic drive(input bit we, input bit addr, input logic [15:0] data,
                       input bit sel, input logic [15:0] a, input logic [15:0] b,
                       input bit clr);
    @(posedge clk_i);
    #1;
    wr_en_i = we; wr_addr_i = addr; wr_data_i = data;
    tmr_sel_i = sel; tmr_a_i = a; tmr_b_i = b; flag_clr_i = clr;
  endtask

  task automatic expect_o(input bit p, input bit f, input bit i,
                          input bit ra, input bit rb, input string req);
    item_t it;
    it.exp = {p, f, i, ra, rb};
    it.req = req;
    sb_q.push_back(it);
  endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    drive(0,0,16'h0000,0,16'd5,16'd7,0);  expect_o(0,0,0,0,0,"R1 reset state");
    drive(1,1,16'h0040,0,16'd0,16'd7,0);  expect_o(0,0,0,0,0,"R1 idle after compare write");
    drive(1,0,16'h0018,0,16'd1,16'd7,0);  expect_o(0,0,0,0,0,"R10 nonzero write keeps pin");
    drive(0,0,16'h0000,0,16'h40,16'd7,0); expect_o(0,0,0,0,0,"R2 match cycle");
    drive(0,0,16'h0000,0,16'h40,16'd7,1); expect_o(1,1,1,0,0,"R2 set high");
    drive(0,0,16'h0000,0,16'h40,16'd7,0); expect_o(1,0,0,0,0,"R8 no refire while held");
    drive(1,0,16'h0019,0,16'h41,16'd7,0); expect_o(1,0,0,0,0,"R10 mode write keeps pin");
    drive(0,0,16'h0000,0,16'h40,16'd7,0); expect_o(1,0,0,0,0,"R3 match cycle");
    drive(0,0,16'h0000,0,16'h41,16'd7,0); expect_o(0,1,1,0,0,"R3 drive low");
    drive(1,0,16'h0002,0,16'h42,16'd7,1); expect_o(0,1,1,0,0,"R12 enable still old");
    drive(0,0,16'h0000,0,16'h40,16'd7,0); expect_o(0,0,0,0,0,"R4 match cycle");
    drive(0,0,16'h0000,0,16'h41,16'd7,0); expect_o(1,1,0,0,0,"R4 toggle up, R12 masked");
    drive(0,0,16'h0000,0,16'h40,16'd7,1); expect_o(1,1,0,0,0,"R7 match with clear");
    drive(0,0,16'h0000,0,16'h41,16'd7,0); expect_o(0,1,0,0,0,"R7 set wins, R4 toggle down");
    drive(1,0,16'h001A,0,16'h42,16'd7,1); expect_o(0,1,0,0,0,"R12 masked flag");
    drive(0,0,16'h0000,0,16'h40,16'd7,0); expect_o(0,0,0,0,0,"R5 match cycle");
    drive(0,0,16'h0000,0,16'h41,16'd7,0); expect_o(0,1,1,0,0,"R5 flag only");
    drive(1,0,16'h001B,0,16'h42,16'd7,1); expect_o(0,1,1,0,0,"R7 flag held");
    drive(0,0,16'h0000,0,16'h40,16'd7,0); expect_o(0,0,0,1,0,"R6 reset timer A");
    drive(0,0,16'h0000,0,16'h00,16'd7,0); expect_o(0,1,1,0,0,"R6 single pulse");
    drive(0,0,16'h0000,1,16'h40,16'd5,1); expect_o(0,1,1,0,0,"R9 timer A ignored");
    drive(0,0,16'h0000,1,16'h40,16'h40,0); expect_o(0,0,0,0,1,"R9 reset timer B");
    drive(0,0,16'h0000,1,16'h40,16'h00,0); expect_o(0,1,1,0,0,"R6 B single pulse");
    drive(1,0,16'h0018,1,16'h40,16'h42,1); expect_o(0,1,1,0,0,"R7 flag held B");
    drive(0,0,16'h0000,1,16'h40,16'h40,0); expect_o(0,0,0,0,0,"R2 match on B");
    drive(0,0,16'h0000,1,16'h40,16'h41,0); expect_o(1,1,1,0,0,"R2 set high via B");
    drive(1,0,16'h0015,1,16'h40,16'h42,1); expect_o(1,1,1,0,0,"R11 write undefined mode");
    drive(0,0,16'h0000,1,16'h40,16'h40,0); expect_o(1,0,0,0,0,"R11 match ignored");
    drive(0,0,16'h0000,1,16'h40,16'h41,0); expect_o(1,0,0,0,0,"R11 no action");
    drive(1,0,16'h0000,1,16'h40,16'h42,0); expect_o(1,0,0,0,0,"R10 zero write cycle");
    drive(0,0,16'h0000,1,16'h40,16'h43,0); expect_o(0,0,0,0,0,"R10 forced low");
    @(posedge clk_i);
    @(negedge clk_i);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule